// File: doc/BRIEF.md
# Power-Management Event Timer with System Control Interrupt

This block keeps a free-running 24-bit timer for power management, a small set of sticky event status bits, a matching enable register and one level-sensitive system control interrupt (SCI). The timer advances by one on each cycle where `tick_en` is high. That input stands for the fixed timer rate, which is produced outside the block. Whenever the timer's most significant bit changes value, an overflow status bit is latched. This happens twice per full wrap. Two event pulse inputs, one for the real-time clock alarm and one for the power button, latch their own status bits.

Software uses a narrow register port. The address is reduced to its low six bits before decoding. A write to the status offset clears the bits written as one. A write to the enable offset loads the enable register. Reads are combinational and return the status, the enable register or the zero-extended timer. SCI stays high as long as any of the four interrupt-capable status bits is set together with its enable bit.

Top module: `pm_event_timer`

## Requirements
- R1: The timer increments by one on each clock where `tick_en` is 1, holds its value otherwise, and wraps from its all-ones value to 0.
- R2: A read at offset 0x08 returns the timer value zero-extended to 32 bits.
- R3: Status bit 0 (overflow) is set on the clock edge where the timer's top bit changes value, both when it rises and when it falls back to 0 at the wrap.
- R4: Once set, the overflow bit stays set until software clears it, and a later change of the top bit leaves nothing further pending. A single clear leaves it at 0.
- R5: A pulse on `rtc_evt` sets status bit 10 and a pulse on `pwrbtn_evt` sets status bit 8. Status bit 5 (global) has no source, and no status bit other than 0, 5, 8 and 10 ever reads as 1.
- R6: A write at offset 0x00 clears every status bit whose write data bit is 1 and leaves the bits written as 0 unchanged.
- R7: When an event sets a status bit in the same cycle as a write clears that bit, the bit ends up set.
- R8: A write at offset 0x02 loads all 16 bits of the enable register, and a read at offset 0x02 returns it.
- R9: Only `addr[5:0]` is decoded for reads and writes, so offset 0x42 acts as 0x02 and 0x40 acts as 0x00.
- R10: Reads at offsets other than 0x00, 0x02 and 0x08 return 0. Writes to those offsets change neither status nor enable.
- R11: `sci` is 1 exactly when status AND enable is nonzero in bits 10, 8, 5 or 0. Enable bits at other positions never raise it.
- R12: Reset (`rst_n` low, asynchronous) clears the timer, status and enable registers, so `sci` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer advance enable, one per timer period |
| rtc_evt | input | 1 | Real-time clock alarm event pulse |
| pwrbtn_evt | input | 1 | Power button event pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 16 | Register address; only the low 6 bits are decoded |
| wdata | input | 16 | Register write data |
| rdata | output | 32 | Combinational read data for `addr` |
| sci | output | 1 | Level-sensitive system control interrupt |

## Verification
The hardest state to reach from the ports is a change of the timer's top bit, because at full width that takes millions of ticks in each direction. The bench builds the block with the timer width parameter set to 8 bits. It counts ticks up to one step short of each edge of the top bit, checks that the overflow bit is still clear there, and then steps across the edge. It does this for the rising change, for the falling change at the wrap, and for a second change while the bit is already pending.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int REG_W  = 16;
    localparam int RD_W   = 32;
    localparam int DEC_W  = 6;

    localparam int STS_OVF = 0;
    localparam int STS_GBL = 5;
    localparam int STS_PWR = 8;
    localparam int STS_RTC = 10;

    localparam logic [REG_W-1:0] SCI_MASK =
        REG_W'((1 << STS_RTC) | (1 << STS_PWR) | (1 << STS_GBL) | (1 << STS_OVF));

    localparam logic [DEC_W-1:0] OFF_STS = 6'h00;
    localparam logic [DEC_W-1:0] OFF_EN  = 6'h02;
    localparam logic [DEC_W-1:0] OFF_TMR = 6'h08;

    typedef logic [REG_W-1:0] pm_reg_t;
endpackage

// File: rtl/pm_tmr.sv
module pm_tmr #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [TMR_W-1:0] cnt_o,
    output logic             msb_flip_o
);
    localparam int MSB = TMR_W - 1;

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        msb_flip_o = st_d.cnt[MSB] ^ st_q.cnt[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ovf_set_i,
    input  logic    rtc_i,
    input  logic    pwr_i,
    input  logic    clr_we_i,
    input  logic    en_we_i,
    input  pm_reg_t wdata_i,
    output pm_reg_t sts_o,
    output pm_reg_t en_o
);
    typedef struct packed {
        pm_reg_t sts;
        pm_reg_t en;
    } regs_t;

    regs_t   rg_d, rg_q;
    pm_reg_t set_vec;
    pm_reg_t clr_vec;

    always_comb begin
        set_vec          = '0;
        set_vec[STS_OVF] = ovf_set_i;
        set_vec[STS_PWR] = pwr_i;
        set_vec[STS_RTC] = rtc_i;
        clr_vec          = clr_we_i ? wdata_i : '0;

        rg_d     = rg_q;
        // a set in the same cycle as a clear takes priority
        rg_d.sts = (rg_q.sts & ~clr_vec) | set_vec;
        if (en_we_i) begin
            rg_d.en = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign sts_o = rg_q.sts;
    assign en_o  = rg_q.en;
endmodule

// File: rtl/pm_rd_mux.sv
module pm_rd_mux
    import pm_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input  logic [DEC_W-1:0] off_i,
    input  pm_reg_t          sts_i,
    input  pm_reg_t          en_i,
    input  logic [TMR_W-1:0] tmr_i,
    output logic [RD_W-1:0]  rdata_o
);
    always_comb begin
        case (off_i)
            OFF_STS: rdata_o = RD_W'(sts_i);
            OFF_EN:  rdata_o = RD_W'(en_i);
            OFF_TMR: rdata_o = RD_W'(tmr_i);
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/pm_event_timer.sv
module pm_event_timer
    import pm_pkg::*;
#(
    parameter int TMR_W  = 24,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              rtc_evt,
    input  logic              pwrbtn_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [RD_W-1:0]   rdata,
    output logic              sci
);
    logic [DEC_W-1:0] off;
    logic             addr_hi_unused;
    logic [TMR_W-1:0] tmr_q;
    logic             msb_flip;
    pm_reg_t          sts_q;
    pm_reg_t          en_q;
    logic             clr_we;
    logic             en_we;

    assign off            = addr[DEC_W-1:0];
    assign addr_hi_unused = ^addr[ADDR_W-1:DEC_W];
    assign clr_we         = wr_en && (off == OFF_STS);
    assign en_we          = wr_en && (off == OFF_EN);

    pm_tmr #(.TMR_W(TMR_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_en),
        .cnt_o      (tmr_q),
        .msb_flip_o (msb_flip)
    );

    pm_evt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_set_i (msb_flip),
        .rtc_i     (rtc_evt),
        .pwr_i     (pwrbtn_evt),
        .clr_we_i  (clr_we),
        .en_we_i   (en_we),
        .wdata_i   (wdata),
        .sts_o     (sts_q),
        .en_o      (en_q)
    );

    pm_rd_mux #(.TMR_W(TMR_W)) u_rd (
        .off_i   (off),
        .sts_i   (sts_q),
        .en_i    (en_q),
        .tmr_i   (tmr_q),
        .rdata_o (rdata)
    );

    assign sci = |(sts_q & en_q & SCI_MASK);
endmodule

// File: rtl/pm_event_timer_chk.sv
module pm_event_timer_chk
    import pm_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             rtc_evt,
    input logic             pwrbtn_evt,
    input logic             wr_en,
    input logic [DEC_W-1:0] off,
    input pm_reg_t          wdata,
    input logic [RD_W-1:0]  rdata,
    input logic             sci,
    input logic [TMR_W-1:0] tmr_q,
    input logic             ovf_sts,
    input logic             pwr_sts,
    input logic             rtc_sts,
    input pm_reg_t          en_q
);
    logic at_half;
    assign at_half = &tmr_q[TMR_W-2:0];

    // R1
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (tmr_q == TMR_W'($past(tmr_q) + 1'b1)));

    // R1
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(tmr_q));

    // R3
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && at_half) |=> ovf_sts);

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sts && !(wr_en && off == OFF_STS && wdata[STS_OVF])) |=> ovf_sts);

    // R5
    rtc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_evt |=> rtc_sts);

    // R5
    pwr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwrbtn_evt |=> pwr_sts);

    // R8
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_EN) |=> (en_q == $past(wdata)));

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off != OFF_STS && off != OFF_EN && off != OFF_TMR) |-> (rdata == '0));

    // R11
    sci_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_STS && wdata == '1 && !rtc_evt && !pwrbtn_evt
         && !(tick_en && at_half)) |=> !sci);
endmodule

bind pm_event_timer pm_event_timer_chk #(.TMR_W(TMR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .rtc_evt    (rtc_evt),
    .pwrbtn_evt (pwrbtn_evt),
    .wr_en      (wr_en),
    .off        (off),
    .wdata      (wdata),
    .rdata      (rdata),
    .sci        (sci),
    .tmr_q      (tmr_q),
    .ovf_sts    (sts_q[0]),
    .pwr_sts    (sts_q[8]),
    .rtc_sts    (sts_q[10]),
    .en_q       (en_q)
);

// File: tb/test_pm_event_timer.sv
module test_pm_event_timer;
    localparam int TW = 8;
    localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [15:0] data;
        logic [31:0] exp;
        logic        sci;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam logic [70:0] TBL [NV] = '{
        {OP_RD, 16'h0000, 16'h0000, 32'h0000, 1'b0, 4'd12}, // R12
        {OP_RD, 16'h0002, 16'h0000, 32'h0000, 1'b0, 4'd12}, // R12
        {OP_RD, 16'h0008, 16'h0000, 32'h0000, 1'b0, 4'd2},  // R2
        {OP_WR, 16'h0002, 16'h0521, 32'h0000, 1'b0, 4'd8},  // R8
        {OP_RD, 16'h0002, 16'h0000, 32'h0521, 1'b0, 4'd8},  // R8
        {OP_EV, 16'h0000, 16'h0001, 32'h0000, 1'b1, 4'd11}, // R11
        {OP_RD, 16'h0000, 16'h0000, 32'h0400, 1'b1, 4'd5},  // R5
        {OP_EV, 16'h0000, 16'h0002, 32'h0000, 1'b1, 4'd5},  // R5
        {OP_RD, 16'h0000, 16'h0000, 32'h0500, 1'b1, 4'd5},  // R5
        {OP_WR, 16'h0000, 16'h0400, 32'h0000, 1'b1, 4'd6},  // R6
        {OP_RD, 16'h0000, 16'h0000, 32'h0100, 1'b1, 4'd6},  // R6
        {OP_WR, 16'h0042, 16'h0100, 32'h0000, 1'b1, 4'd9},  // R9
        {OP_RD, 16'h0002, 16'h0000, 32'h0100, 1'b1, 4'd9},  // R9
        {OP_RD, 16'h0040, 16'h0000, 32'h0100, 1'b1, 4'd9},  // R9
        {OP_RD, 16'hFFC2, 16'h0000, 32'h0100, 1'b1, 4'd9},  // R9
        {OP_WR, 16'h0004, 16'hFFFF, 32'h0000, 1'b1, 4'd10}, // R10
        {OP_RD, 16'h0004, 16'h0000, 32'h0000, 1'b1, 4'd10}, // R10
        {OP_RD, 16'h0000, 16'h0000, 32'h0100, 1'b1, 4'd10}, // R10
        {OP_RD, 16'h0002, 16'h0000, 32'h0100, 1'b1, 4'd10}, // R10
        {OP_WR, 16'h0000, 16'h0100, 32'h0000, 1'b0, 4'd6},  // R6
        {OP_WR, 16'h0002, 16'hFADE, 32'h0000, 1'b0, 4'd11}, // R11
        {OP_EV, 16'h0000, 16'h0003, 32'h0000, 1'b0, 4'd11}, // R11
        {OP_RD, 16'h0000, 16'h0000, 32'h0500, 1'b0, 4'd5},  // R5
        {OP_WR, 16'h0002, 16'h0400, 32'h0000, 1'b1, 4'd11}, // R11
        {OP_WR, 16'h0000, 16'hFFFF, 32'h0000, 1'b0, 4'd6},  // R6
        {OP_RD, 16'h0000, 16'h0000, 32'h0000, 1'b0, 4'd6}   // R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        rtc_evt = 1'b0;
    logic        pwrbtn_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [31:0] rdata;
    logic        sci;

    int n_chk = 0;
    int n_fail = 0;
    int exp_tmr = 0;

    always #4 clk = ~clk;

    pm_event_timer #(.TMR_W(TW), .ADDR_W(16)) i_pm_event_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .rtc_evt    (rtc_evt),
        .pwrbtn_evt (pwrbtn_evt),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .sci        (sci)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input int req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d,
                      input logic rtc, input logic pwr);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; rtc_evt = rtc; pwrbtn_evt = pwr;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; rtc_evt = 1'b0; pwrbtn_evt = 1'b0;
    endtask

    task automatic evt(input logic rtc, input logic pwr);
        @(negedge clk);
        rtc_evt = rtc; pwrbtn_evt = pwr;
        @(negedge clk);
        rtc_evt = 1'b0; pwrbtn_evt = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp,
                      input int req, input string what);
        addr = a;
        #1;
        check(rdata, exp, req, what);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        exp_tmr = (exp_tmr + n) % (1 << TW);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check({31'd0, sci}, 32'd0, 12, "sci after reset"); // R12

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(TBL[i]);
            case (v.op)
                OP_WR:   wr(v.addr, v.data, 1'b0, 1'b0);
                OP_EV:   evt(v.data[0], v.data[1]);
                default: rd(v.addr, v.exp, int'(v.req), "table read");
            endcase
            #1;
            check({31'd0, sci}, {31'd0, v.sci}, int'(v.req), "table sci");
        end

        // R7: event and clear of bit 10 in one cycle, event wins
        wr(16'h0000, 16'h0400, 1'b1, 1'b0);
        rd(16'h0000, 32'h0400, 7, "set beats clear");
        check({31'd0, sci}, 32'd1, 7, "sci after set beats clear");
        wr(16'h0000, 16'hFFFF, 1'b0, 1'b0);

        // R1 / R2: count and hold
        ticks(5);
        rd(16'h0008, 32'(exp_tmr), 1, "count after 5 ticks");
        repeat (3) @(negedge clk);
        rd(16'h0008, 32'(exp_tmr), 1, "hold without tick");

        // R3 rising edge of top bit, overflow enabled for sci
        wr(16'h0002, 16'h0001, 1'b0, 1'b0);
        ticks((1 << (TW - 1)) - 1 - exp_tmr);
        rd(16'h0008, 32'h7F, 2, "timer one before half");
        rd(16'h0000, 32'h0, 3, "no overflow before half");
        ticks(1);
        rd(16'h0000, 32'h1, 3, "overflow at top bit rise");
        check({31'd0, sci}, 32'd1, 11, "sci from overflow");
        wr(16'h0000, 16'h0001, 1'b0, 1'b0);
        rd(16'h0000, 32'h0, 6, "overflow cleared");

        // R3 falling edge at wrap, R1 wrap
        ticks((1 << TW) - 1 - exp_tmr);
        rd(16'h0008, 32'hFF, 1, "timer at all ones");
        rd(16'h0000, 32'h0, 3, "no overflow before wrap");
        ticks(1);
        rd(16'h0008, 32'h0, 1, "timer wraps to zero");
        rd(16'h0000, 32'h1, 3, "overflow at top bit fall");

        // R4: another toggle while pending, single clear suffices
        ticks(1 << (TW - 1));
        rd(16'h0000, 32'h1, 4, "overflow still set");
        wr(16'h0000, 16'h0001, 1'b0, 1'b0);
        @(negedge clk);
        rd(16'h0000, 32'h0, 4, "nothing pending after clear");
        check({31'd0, sci}, 32'd0, 4, "sci low after clear");

        // R12: reset mid-run
        ticks(3);
        wr(16'h0002, 16'h0500, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_tmr = 0;
        rd(16'h0008, 32'h0, 12, "timer after reset");
        rd(16'h0000, 32'h0, 12, "status after reset");
        rd(16'h0002, 32'h0, 12, "enable after reset");
        check({31'd0, sci}, 32'd0, 12, "sci after mid reset");

        finish_run();
    end
endmodule